// File: doc/BRIEF.md
# Core Sleep and Event Controller

This block decides when a small processor core goes to sleep and when it wakes up. It holds a word-wide sleep control register with three control bits. It watches single-cycle strobes from the instruction decoder for wait-for-interrupt, wait-for-event and send-event. It also watches exception-return information, the per-interrupt pending and enable vectors, an external receive-event line and a debug halt request. From these inputs it drives a sleeping flag, a deep-sleep indication, a transmit-event pulse, a one-cycle wake pulse and a flag that tells the core to skip unstacking.

A sticky event latch is the memory of the wait-for-event path. The latch is set by a received event, by the core's own send-event, or by a newly pending interrupt when that option is enabled. A wait-for-event consumes the latch. Sleep-on-exit lets an interrupt-driven core fall asleep straight from an exception return to thread mode. In that case the register restore is skipped, and the skip is cancelled when a debug halt is what wakes the core. Gating of clocks and power, instruction execution and stacking are done elsewhere. This block only produces the signals for them.

Top module: `core_sleep_ctrl`

## Requirements
- R1: The control register resets to zero. A word-size write (`reg_size` = 2'b10) at address `CTRL_ADDR` stores the write data masked to bits 1, 2 and 4. `reg_rdata` returns the stored word when `reg_addr` equals `CTRL_ADDR`, and zero at any other address. All unused bits read as zero.
- R2: A write with `reg_size` other than 2'b10 leaves the register unchanged.
- R3: A `sev_pulse` makes `tx_evt` high for exactly the following cycle, and it also sets the event latch.
- R4: A `rx_evt` pulse sets the event latch. While the core sleeps from wait-for-event, a set latch raises `wake` one cycle later, and the latch is cleared when that wait completes.
- R5: A wait-for-event issued while the latch is set does not sleep. It clears the latch, so the next wait-for-event sleeps.
- R6: When bit 4 is set, any interrupt whose pending bit rises from 0 to 1 sets the event latch, even if its enable bit is 0. When bit 4 is clear, a rising pending bit sets nothing.
- R7: An interrupt whose pending bit was already high before the wait-for-event sleep began does not wake the core while that bit stays high.
- R8: Wait-for-interrupt sleep (and wait-for-event sleep) ends when some interrupt is both pending and enabled, or when `dbg_halt` is high. A pending interrupt that is disabled does not end it.
- R9: When bit 1 is set, an exception return to thread mode (`exc_ret` with `exc_to_thread` = 1) enters sleep in the next cycle with `skip_unstack` high. A return to a handler, or a return with bit 1 clear, does not sleep.
- R10: If a sleep-on-exit sleep ends through `dbg_halt`, `skip_unstack` is low in the wake cycle. If it ends through an interrupt only, `skip_unstack` stays high in the wake cycle and drops in the cycle after.
- R11: `deep_sleep` is high only while `sleeping` is high and bit 2 is set.
- R12: `wake` is a one-cycle pulse. `sleeping` and `deep_sleep` are low in the same cycle that `wake` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register access address |
| reg_size | input | 2 | Access size, 2'b10 means full word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational) |
| wfi_pulse | input | 1 | Wait-for-interrupt decoded |
| wfe_pulse | input | 1 | Wait-for-event decoded |
| sev_pulse | input | 1 | Send-event decoded |
| exc_ret | input | 1 | Exception return taking place |
| exc_to_thread | input | 1 | The return goes to thread mode |
| irq_pend | input | N_IRQ | Per-interrupt pending bits |
| irq_en | input | N_IRQ | Per-interrupt enable bits |
| rx_evt | input | 1 | External receive-event pulse |
| dbg_halt | input | 1 | Debug halt request |
| sleeping | output | 1 | Core is asleep |
| deep_sleep | output | 1 | Asleep in deep mode |
| tx_evt | output | 1 | Transmit-event pulse |
| wake | output | 1 | One-cycle wake pulse |
| skip_unstack | output | 1 | Skip register restore on the pending exception |

## Verification
The checker assumes the decoder sends at most one of `wfi_pulse`, `wfe_pulse` and a sleep-on-exit return in any cycle. It also assumes a core that is asleep issues no instruction strobes. The wake-cause property further assumes that wake comes only from the listed sources. The stimulus keeps to these assumptions: every instruction strobe is a single-cycle pulse given while `sleeping` is low, with nothing else in that cycle. The pending and enable vectors change only in cycles that carry no instruction strobe.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WFI  = 2'd1,
        ST_WFE  = 2'd2,
        ST_EXIT = 2'd3
    } slp_state_e;

    localparam int          BIT_EXIT_SLEEP = 1;
    localparam int          BIT_DEEP       = 2;
    localparam int          BIT_PEND_EVT   = 4;
    localparam logic [31:0] CTRL_KEEP      = (32'd1 << BIT_EXIT_SLEEP)
                                           | (32'd1 << BIT_DEEP)
                                           | (32'd1 << BIT_PEND_EVT);
    localparam logic [1:0]  SIZE_WORD      = 2'b10;

endpackage

// File: rtl/slp_ctrl_reg.sv
module slp_ctrl_reg
    import slp_pkg::*;
#(
    parameter int             ADDR_W    = 32,
    parameter int             DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(32'hE000_ED10)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              exit_sleep_en,
    output logic              deep_en,
    output logic              pend_evt_en
);

    localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = (reg_addr == CTRL_ADDR);
        if (reg_wr && hit && reg_size == SIZE_WORD) begin
            st_d.word = reg_wdata & KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_word     = st_q.word;
    assign reg_rdata     = hit ? st_q.word : '0;
    assign exit_sleep_en = st_q.word[BIT_EXIT_SLEEP];
    assign deep_en       = st_q.word[BIT_DEEP];
    assign pend_evt_en   = st_q.word[BIT_PEND_EVT];

endmodule

// File: rtl/slp_evt_unit.sv
module slp_evt_unit #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sev_pulse,
    input  logic             rx_evt,
    input  logic             pend_evt_en,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic             consume,
    output logic             evt_latched,
    output logic             tx_evt
);

    typedef struct packed {
        logic             evt;
        logic             tx;
        logic [N_IRQ-1:0] pend_prev;
    } evt_st_t;

    evt_st_t          st_d, st_q;
    logic [N_IRQ-1:0] pend_rise;
    logic             any_rise;

    // Per-interrupt inactive-to-pending edge detection
    for (genvar g = 0; g < N_IRQ; g++) begin : g_edge
        assign pend_rise[g] = irq_pend[g] && !st_q.pend_prev[g];
    end

    assign any_rise = |pend_rise;

    always_comb begin
        st_d           = st_q;
        st_d.pend_prev = irq_pend;
        st_d.tx        = sev_pulse;
        // A new event in the consuming cycle is kept (set wins)
        st_d.evt       = (st_q.evt && !consume) || sev_pulse || rx_evt
                         || (pend_evt_en && any_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_latched = st_q.evt;
    assign tx_evt      = st_q.tx;

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_pulse,
    input  logic             wfe_pulse,
    input  logic             exc_ret,
    input  logic             exc_to_thread,
    input  logic             exit_sleep_en,
    input  logic             deep_en,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             dbg_halt,
    input  logic             evt_latched,
    output logic             consume,
    output logic             sleeping,
    output logic             deep_sleep,
    output logic             wake,
    output logic             skip_unstack
);

    typedef struct packed {
        slp_state_e st;
        logic       deep;
        logic       wake;
        logic       skip;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    irq_wake;
    logic    int_wake;

    assign irq_wake = |(irq_pend & irq_en);
    assign int_wake = irq_wake || dbg_halt;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        consume   = 1'b0;
        unique case (st_q.st)
            ST_RUN: begin
                st_d.skip = 1'b0;
                if (exc_ret && exc_to_thread && exit_sleep_en) begin
                    st_d.st   = ST_EXIT;
                    st_d.skip = 1'b1;
                end else if (wfi_pulse) begin
                    st_d.st = ST_WFI;
                end else if (wfe_pulse) begin
                    if (evt_latched) consume = 1'b1;
                    else             st_d.st = ST_WFE;
                end
            end
            ST_WFI: begin
                if (int_wake) begin
                    st_d.st   = ST_RUN;
                    st_d.wake = 1'b1;
                end
            end
            ST_WFE: begin
                if (evt_latched || int_wake) begin
                    st_d.st   = ST_RUN;
                    st_d.wake = 1'b1;
                    consume   = 1'b1;
                end
            end
            ST_EXIT: begin
                if (int_wake) begin
                    st_d.st   = ST_RUN;
                    st_d.wake = 1'b1;
                    st_d.skip = !dbg_halt;
                end
            end
            default: st_d.st = ST_RUN;
        endcase
        st_d.deep = (st_d.st != ST_RUN) && deep_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: ST_RUN, deep: 1'b0, wake: 1'b0, skip: 1'b0};
        else        st_q <= st_d;
    end

    assign sleeping     = (st_q.st != ST_RUN);
    assign deep_sleep   = st_q.deep;
    assign wake         = st_q.wake;
    assign skip_unstack = st_q.skip;

endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl
    import slp_pkg::*;
#(
    parameter int                N_IRQ     = 8,
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(32'hE000_ED10)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wfi_pulse,
    input  logic              wfe_pulse,
    input  logic              sev_pulse,
    input  logic              exc_ret,
    input  logic              exc_to_thread,
    input  logic [N_IRQ-1:0]  irq_pend,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic              rx_evt,
    input  logic              dbg_halt,
    output logic              sleeping,
    output logic              deep_sleep,
    output logic              tx_evt,
    output logic              wake,
    output logic              skip_unstack
);

    logic [DATA_W-1:0] ctrl_word;
    logic              exit_sleep_en;
    logic              deep_en;
    logic              pend_evt_en;
    logic              evt_latched;
    logic              consume;

    slp_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_size     (reg_size),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .ctrl_word    (ctrl_word),
        .exit_sleep_en(exit_sleep_en),
        .deep_en      (deep_en),
        .pend_evt_en  (pend_evt_en)
    );

    slp_evt_unit #(.N_IRQ(N_IRQ)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .sev_pulse  (sev_pulse),
        .rx_evt     (rx_evt),
        .pend_evt_en(pend_evt_en),
        .irq_pend   (irq_pend),
        .consume    (consume),
        .evt_latched(evt_latched),
        .tx_evt     (tx_evt)
    );

    slp_fsm #(.N_IRQ(N_IRQ)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wfi_pulse    (wfi_pulse),
        .wfe_pulse    (wfe_pulse),
        .exc_ret      (exc_ret),
        .exc_to_thread(exc_to_thread),
        .exit_sleep_en(exit_sleep_en),
        .deep_en      (deep_en),
        .irq_pend     (irq_pend),
        .irq_en       (irq_en),
        .dbg_halt     (dbg_halt),
        .evt_latched  (evt_latched),
        .consume      (consume),
        .sleeping     (sleeping),
        .deep_sleep   (deep_sleep),
        .wake         (wake),
        .skip_unstack (skip_unstack)
    );

endmodule

// File: rtl/core_sleep_ctrl_chk.sv
module core_sleep_ctrl_chk
    import slp_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_size,
    input logic [DATA_W-1:0] ctrl_word,
    input logic              sev_pulse,
    input logic [N_IRQ-1:0]  irq_pend,
    input logic [N_IRQ-1:0]  irq_en,
    input logic              dbg_halt,
    input logic              evt_latched,
    input logic              sleeping,
    input logic              deep_sleep,
    input logic              tx_evt,
    input logic              wake,
    input logic              skip_unstack
);

    localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP);

    a_r1_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word & ~KEEP) == '0);

    a_r2_narrow_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_size != SIZE_WORD |=> ctrl_word == $past(ctrl_word));

    a_r3_sev_gives_tx: assert property (@(posedge clk) disable iff (!rst_n)
        sev_pulse |=> tx_evt);

    a_r3_tx_needs_sev: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt |-> $past(sev_pulse));

    a_r8_wake_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(|(irq_pend & irq_en)) || $past(dbg_halt) || $past(evt_latched)));

    a_r9_skip_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        skip_unstack |-> (sleeping || wake));

    a_r10_debug_wake_unstacks: assert property (@(posedge clk) disable iff (!rst_n)
        wake && $past(dbg_halt) |-> !skip_unstack);

    a_r11_deep_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |-> sleeping);

    a_r12_wake_ends_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (!sleeping && !deep_sleep && $past(sleeping)));

    a_r12_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

endmodule

bind core_sleep_ctrl core_sleep_ctrl_chk #(
    .N_IRQ (N_IRQ),
    .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_size    (reg_size),
    .ctrl_word   (ctrl_word),
    .sev_pulse   (sev_pulse),
    .irq_pend    (irq_pend),
    .irq_en      (irq_en),
    .dbg_halt    (dbg_halt),
    .evt_latched (evt_latched),
    .sleeping    (sleeping),
    .deep_sleep  (deep_sleep),
    .tx_evt      (tx_evt),
    .wake        (wake),
    .skip_unstack(skip_unstack)
);

// File: tb/tb_core_sleep_ctrl.sv
module tb_core_sleep_ctrl;

    localparam int          N_IRQ  = 8;
    localparam int          ADDR_W = 32;
    localparam int          DATA_W = 32;
    localparam logic [31:0] CADDR  = 32'hE000_ED10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_wr;
    logic [ADDR_W-1:0] reg_addr;
    logic [1:0]        reg_size;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata;
    logic              wfi_pulse, wfe_pulse, sev_pulse, exc_ret, exc_to_thread;
    logic [N_IRQ-1:0]  irq_pend, irq_en;
    logic              rx_evt, dbg_halt;
    logic              sleeping, deep_sleep, tx_evt, wake, skip_unstack;

    always #4 clk = ~clk;

    core_sleep_ctrl #(
        .N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CADDR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wfi_pulse(wfi_pulse), .wfe_pulse(wfe_pulse), .sev_pulse(sev_pulse),
        .exc_ret(exc_ret), .exc_to_thread(exc_to_thread),
        .irq_pend(irq_pend), .irq_en(irq_en), .rx_evt(rx_evt),
        .dbg_halt(dbg_halt), .sleeping(sleeping), .deep_sleep(deep_sleep),
        .tx_evt(tx_evt), .wake(wake), .skip_unstack(skip_unstack)
    );

    typedef struct {
        string       req;
        bit          is_rd;
        logic [31:0] val;
        int          due;
    } exp_t;

    exp_t sb_q[$];
    int   cyc    = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // Monitor: samples 1 ns after each rising edge, pops due items
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                exp_t e;
                logic [31:0] act;
                e   = sb_q.pop_front();
                act = e.is_rd ? reg_rdata
                              : {27'd0, sleeping, deep_sleep, tx_evt, wake, skip_unstack};
                checks++;
                if (act !== e.val) begin
                    errors++;
                    $display("FAIL %s: cycle %0d %s actual=%h expected=%h",
                             e.req, cyc, e.is_rd ? "rdata" : "outs", act, e.val);
                end
            end
        end
    end

    function automatic logic [4:0] o(input bit sl, input bit dp, input bit tx,
                                     input bit wk, input bit sk);
        return {sl, dp, tx, wk, sk};
    endfunction

    task automatic step(input string req, input logic [4:0] e);
        sb_q.push_back('{req: req, is_rd: 1'b0, val: {27'd0, e}, due: cyc + 1});
        @(negedge clk);
    endtask

    task automatic step_rd(input string req, input logic [31:0] v);
        sb_q.push_back('{req: req, is_rd: 1'b1, val: v, due: cyc + 1});
        @(negedge clk);
    endtask

    task automatic wr(input string req, input logic [31:0] d, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] exp_rd);
        reg_wr    = 1'b1;
        reg_wdata = d;
        reg_size  = sz;
        reg_addr  = a;
        step_rd(req, exp_rd);
        reg_wr    = 1'b0;
        reg_addr  = CADDR;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        reg_wr = 0; reg_addr = CADDR; reg_size = 2'b10; reg_wdata = '0;
        wfi_pulse = 0; wfe_pulse = 0; sev_pulse = 0; exc_ret = 0; exc_to_thread = 0;
        irq_pend = '0; irq_en = '0; rx_evt = 0; dbg_halt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step_rd("R1", 32'h0);
        step("R1", o(0, 0, 0, 0, 0));

        // R2 narrow writes have no effect
        wr("R2", 32'hFFFF_FFFF, 2'b01, CADDR, 32'h0);
        wr("R2", 32'hFFFF_FFFF, 2'b00, CADDR, 32'h0);
        // R1 word write is masked, other address not written and reads zero
        wr("R1", 32'hFFFF_FFFF, 2'b10, CADDR, 32'h16);
        wr("R1", 32'h0, 2'b10, CADDR + 4, 32'h0);
        step_rd("R1", 32'h16);
        wr("R1", 32'h0, 2'b10, CADDR, 32'h0);

        // R3 send-event pulse and latch; R5 immediate return
        sev_pulse = 1; step("R3", o(0, 0, 1, 0, 0));
        sev_pulse = 0; wfe_pulse = 1; step("R5", o(0, 0, 0, 0, 0));
        step("R5", o(1, 0, 0, 0, 0));
        wfe_pulse = 0; step("R4", o(1, 0, 0, 0, 0));

        // R4 receive event wakes wait-for-event sleep
        rx_evt = 1; step("R4", o(1, 0, 0, 0, 0));
        rx_evt = 0; step("R4", o(0, 0, 0, 1, 0));
        step("R12", o(0, 0, 0, 0, 0));
        wfe_pulse = 1; step("R4", o(1, 0, 0, 0, 0));
        wfe_pulse = 0; dbg_halt = 1; step("R8", o(0, 0, 0, 1, 0));
        dbg_halt = 0; step("R12", o(0, 0, 0, 0, 0));

        // R6 pend edge of a disabled interrupt gives an event; R7 held pending
        wr("R6", 32'h10, 2'b10, CADDR, 32'h10);
        irq_pend = 8'h01; step("R6", o(0, 0, 0, 0, 0));
        wfe_pulse = 1; step("R6", o(0, 0, 0, 0, 0));
        step("R7", o(1, 0, 0, 0, 0));
        wfe_pulse = 0;
        for (int i = 0; i < 3; i++) step("R7", o(1, 0, 0, 0, 0));
        dbg_halt = 1; step("R8", o(0, 0, 0, 1, 0));
        dbg_halt = 0; irq_pend = '0; step("R12", o(0, 0, 0, 0, 0));
        wr("R6", 32'h0, 2'b10, CADDR, 32'h0);
        irq_pend = 8'h02; step("R6", o(0, 0, 0, 0, 0));
        wfe_pulse = 1; step("R6", o(1, 0, 0, 0, 0));
        wfe_pulse = 0; dbg_halt = 1; step("R8", o(0, 0, 0, 1, 0));
        dbg_halt = 0; irq_pend = '0; step("R8", o(0, 0, 0, 0, 0));

        // R8 wait-for-interrupt: disabled pending ignored, enabled wakes
        irq_pend = 8'h04; step("R8", o(0, 0, 0, 0, 0));
        wfi_pulse = 1; step("R8", o(1, 0, 0, 0, 0));
        wfi_pulse = 0; step("R8", o(1, 0, 0, 0, 0));
        step("R8", o(1, 0, 0, 0, 0));
        irq_en = 8'h04; step("R8", o(0, 0, 0, 1, 0));
        irq_en = '0; irq_pend = '0; step("R12", o(0, 0, 0, 0, 0));

        // R11 deep sleep indication
        wr("R11", 32'h4, 2'b10, CADDR, 32'h4);
        wfi_pulse = 1; step("R11", o(1, 1, 0, 0, 0));
        wfi_pulse = 0; step("R11", o(1, 1, 0, 0, 0));
        dbg_halt = 1; step("R12", o(0, 0, 0, 1, 0));
        dbg_halt = 0; wr("R11", 32'h0, 2'b10, CADDR, 32'h0);

        // R9 sleep-on-exit, R10 skip flag handling
        wr("R9", 32'h2, 2'b10, CADDR, 32'h2);
        exc_ret = 1; exc_to_thread = 0; step("R9", o(0, 0, 0, 0, 0));
        exc_to_thread = 1; step("R9", o(1, 0, 0, 0, 1));
        exc_ret = 0; exc_to_thread = 0; step("R9", o(1, 0, 0, 0, 1));
        dbg_halt = 1; step("R10", o(0, 0, 0, 1, 0));
        dbg_halt = 0; step("R10", o(0, 0, 0, 0, 0));
        exc_ret = 1; exc_to_thread = 1; step("R9", o(1, 0, 0, 0, 1));
        exc_ret = 0; exc_to_thread = 0; irq_pend = 8'h08; irq_en = 8'h08;
        step("R10", o(0, 0, 0, 1, 1));
        step("R10", o(0, 0, 0, 0, 0));
        irq_pend = '0; irq_en = '0;
        wr("R9", 32'h0, 2'b10, CADDR, 32'h0);
        exc_ret = 1; exc_to_thread = 1; step("R9", o(0, 0, 0, 0, 0));
        exc_ret = 0; exc_to_thread = 0; step("R9", o(0, 0, 0, 0, 0));

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule